// File: doc/BRIEF.md
# Bit and Error Count Accumulator with Sticky Status and Interrupt

This block sits behind the receive synchronizer of a bit error rate tester. It counts every received bit position offered to it and every bit among them that was in error. Counting happens only while the synchronizer reports lock. When the measurement interval ends, a latch strobe moves both running counts into holding registers that a host can read, and the running counts restart together. The host divides the two snapshots to obtain the error ratio for that interval.

Next to the counts it keeps an eight-bit status word. The bits follow three rules. Event bits (error seen, bit-count overflow, error-count overflow) stay set until the host reads the status. Condition bits (long run of ones, long run of zeros, loss of lock) stay set while their condition holds and also survive a read that happens while it holds. The lock bit simply follows the synchronizer. An eight-bit mask selects which status bits drive an active-low interrupt.

The host reads through a small port: an address and a one-cycle read strobe. Read data is registered and stays on its output until the next strobe.

Top module: `ber_stat_core`

## Requirements
- R1: While `sync_live` is 1, each cycle with `bit_vld` = 1 adds one to the running bit count, and each cycle with `bit_vld` = 1 and `bit_err` = 1 adds one to the running error count.
- R2: While `sync_live` is 0, neither running count changes, whatever `bit_vld` and `bit_err` do.
- R3: A 0-to-1 change of (`latch_pin` OR `latch_ctl`) copies both running counts, as they stood before that cycle, into the holding registers. In that same cycle both running counts restart, each at 1 if it counts in that cycle and at 0 otherwise. Holding the level high does not trigger another copy.
- R4: Read map: addresses 0 to 3 return the held bit count, least significant byte at 0. Addresses 4 to 7 return the held error count in the same byte order. Address 8 returns the status word. Every other address returns 0. Count bits above the counter width read as 0. `rd_data` takes its new value on the clock edge where `rd_stb` is 1 and keeps it until the next strobe.
- R5: Status bit positions: 7 always 0, 6 run of ones, 5 run of zeros, 4 loss of lock, 3 error seen, 2 bit-count overflow, 1 error-count overflow, 0 lock. Bit 0 shows `sync_live` as sampled on the read edge.
- R6: When a running count increments past its all-ones value it wraps to zero. It keeps counting and sets its overflow bit: 2 for the bit count, 1 for the error count.
- R7: Status bits 3, 2 and 1 stay set until a read of address 8. That read returns them still set and clears them on the same edge.
- R8: Bit 6 follows `all_ones_cond`, bit 5 follows `all_zeros_cond`, and bit 4 follows the inverse of `sync_live`. Each is set on every edge where its condition holds, and a status read clears it only if its condition is false on that edge.
- R9: If an event that sets a status bit falls on the same edge as a clearing status read, the bit stays set after that edge.
- R10: `irq_n` is 0 in the cycle after any edge on which some status bit and its `irq_mask` bit are both 1. Otherwise it is 1.
- R11: After reset the running counts, held counts, sticky status bits and `rd_data` are 0, and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | One received bit position this cycle |
| bit_err | input | 1 | That bit was in error |
| sync_live | input | 1 | Synchronizer locked |
| all_ones_cond | input | 1 | Long run of ones present |
| all_zeros_cond | input | 1 | Long run of zeros present |
| latch_pin | input | 1 | Latch strobe from a pin |
| latch_ctl | input | 1 | Latch strobe from a control bit |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| rd_addr | input | 4 | Read address |
| irq_mask | input | 8 | Interrupt enable per status bit |
| rd_data | output | 8 | Registered read data |
| irq_n | output | 1 | Interrupt, active low |

## Verification
Two pairs of functions can meet on a single edge, and each pair is driven into that edge on purpose. In the first, the latch strobe rises in the cycle that also carries a counted bit. The bench expects the snapshot to leave that bit out and the next interval to start at one. In the second, a status read clears the error-seen bit on the same edge that a new counted error sets it. The bench expects the read to return the old value and a second read to show the bit set, since the event wins. Wrap-around is reached with a narrowed counter, and the status must show overflow while the held counts show the wrapped values.

// File: rtl/ber_stat_pkg.sv
`timescale 1ns/1ps
package ber_stat_pkg;
  localparam int RD_ADDR_W = 4;
  localparam int STAT_W    = 8;
  localparam int BYTE_W    = 8;
  localparam int HOLD_BYTES = 4;

  // status bit positions (host software decodes these)
  localparam int ST_SYNC  = 0;
  localparam int ST_ECOF  = 1;
  localparam int ST_BCOF  = 2;
  localparam int ST_BED   = 3;
  localparam int ST_LOS   = 4;
  localparam int ST_ZEROS = 5;
  localparam int ST_ONES  = 6;
  localparam int ST_SPARE = 7;

  localparam logic [RD_ADDR_W-1:0] A_STAT = 4'd8;

  typedef enum logic {RULE_STICKY, RULE_PASS} stat_rule_e;

  function automatic stat_rule_e rule_of(input int idx);
    if (idx == ST_SYNC || idx == ST_SPARE) return RULE_PASS;
    return RULE_STICKY;
  endfunction
endpackage

// File: rtl/ber_rise_det.sv
`timescale 1ns/1ps
module ber_rise_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;
  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end
  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/ber_event_cnt.sv
`timescale 1ns/1ps
module ber_event_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         snap,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] hold_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      hold_q <= '0;
    end else if (snap) begin
      hold_q <= cnt_q;
      cnt_q  <= W'(inc);
    end else if (inc) begin
      cnt_q  <= cnt_q + W'(1);
    end
  end

  assign wrap_o = inc & ~snap & (&cnt_q);
  assign cnt_o  = cnt_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/ber_stat_reg.sv
`timescale 1ns/1ps
module ber_stat_reg
  import ber_stat_pkg::*;
#(
  parameter int N = STAT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic         clr,
  output logic [N-1:0] stat_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (rule_of(i) == RULE_PASS) begin : g_pass
      assign stat_o[i] = set_vec[i];
    end else begin : g_sticky
      logic q;
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= set_vec[i] | (q & ~clr);
      end
      assign stat_o[i] = q;
    end
  end
endmodule

// File: rtl/ber_stat_core.sv
`timescale 1ns/1ps
module ber_stat_core
  import ber_stat_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_vld,
  input  logic                 bit_err,
  input  logic                 sync_live,
  input  logic                 all_ones_cond,
  input  logic                 all_zeros_cond,
  input  logic                 latch_pin,
  input  logic                 latch_ctl,
  input  logic                 rd_stb,
  input  logic [RD_ADDR_W-1:0] rd_addr,
  input  logic [STAT_W-1:0]    irq_mask,
  output logic [BYTE_W-1:0]    rd_data,
  output logic                 irq_n
);
  localparam int PAD_W = HOLD_BYTES * BYTE_W;

  logic lat_rise;
  logic bit_inc, err_inc;
  logic [CNT_W-1:0] bit_cnt, err_cnt, bit_hold, err_hold;
  logic bit_wrap, err_wrap;
  logic clr;
  logic [STAT_W-1:0] set_vec, stat;

  ber_rise_det u_lat (
    .clk(clk), .rst(rst), .lvl(latch_pin | latch_ctl), .rise(lat_rise)
  );

  assign bit_inc = bit_vld & sync_live;
  assign err_inc = bit_inc & bit_err;

  ber_event_cnt #(.W(CNT_W)) u_bits (
    .clk(clk), .rst(rst), .inc(bit_inc), .snap(lat_rise),
    .cnt_o(bit_cnt), .hold_o(bit_hold), .wrap_o(bit_wrap)
  );

  ber_event_cnt #(.W(CNT_W)) u_errs (
    .clk(clk), .rst(rst), .inc(err_inc), .snap(lat_rise),
    .cnt_o(err_cnt), .hold_o(err_hold), .wrap_o(err_wrap)
  );

  // status sources
  always_comb begin
    set_vec           = '0;
    set_vec[ST_SYNC]  = sync_live;
    set_vec[ST_ECOF]  = err_wrap;
    set_vec[ST_BCOF]  = bit_wrap;
    set_vec[ST_BED]   = err_inc;
    set_vec[ST_LOS]   = ~sync_live;
    set_vec[ST_ZEROS] = all_zeros_cond;
    set_vec[ST_ONES]  = all_ones_cond;
  end

  assign clr = rd_stb & (rd_addr == A_STAT);

  ber_stat_reg #(.N(STAT_W)) u_stat (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr(clr), .stat_o(stat)
  );

  // read path: held counts split into bytes
  logic [PAD_W-1:0]  bit_pad, err_pad;
  logic [BYTE_W-1:0] bit_bytes [HOLD_BYTES];
  logic [BYTE_W-1:0] err_bytes [HOLD_BYTES];
  logic [BYTE_W-1:0] rd_sel;

  assign bit_pad = PAD_W'(bit_hold);
  assign err_pad = PAD_W'(err_hold);

  for (genvar b = 0; b < HOLD_BYTES; b++) begin : g_byte
    assign bit_bytes[b] = bit_pad[b*BYTE_W +: BYTE_W];
    assign err_bytes[b] = err_pad[b*BYTE_W +: BYTE_W];
  end

  always_comb begin
    if (rd_addr == A_STAT)          rd_sel = stat;
    else if (rd_addr[3:2] == 2'b00) rd_sel = bit_bytes[rd_addr[1:0]];
    else if (rd_addr[3:2] == 2'b01) rd_sel = err_bytes[rd_addr[1:0]];
    else                            rd_sel = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq_n   <= 1'b1;
    end else begin
      if (rd_stb) rd_data <= rd_sel;
      irq_n <= ~|(stat & irq_mask);
    end
  end
endmodule

// File: rtl/ber_stat_chk.sv
`timescale 1ns/1ps
module ber_stat_chk
  import ber_stat_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              sync_live,
  input logic              lat_rise,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [CNT_W-1:0]  err_cnt,
  input logic [CNT_W-1:0]  bit_hold,
  input logic [STAT_W-1:0] stat,
  input logic              clr,
  input logic              bit_wrap,
  input logic              all_ones_cond,
  input logic [STAT_W-1:0] irq_mask,
  input logic              irq_n
);
  AST_NO_COUNT_UNSYNC: assert property (@(posedge clk) disable iff (rst)
    (!sync_live && !lat_rise) |=> ($stable(bit_cnt) && $stable(err_cnt))); // R2
  AST_SNAP_RESTART: assert property (@(posedge clk) disable iff (rst)
    lat_rise |=> (bit_cnt <= CNT_W'(1))); // R3
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    !lat_rise |=> $stable(bit_hold)); // R3
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
    bit_wrap |=> stat[ST_BCOF]); // R6
  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (rst)
    (stat[ST_BED] && !clr) |=> stat[ST_BED]); // R7
  AST_COND_HOLD: assert property (@(posedge clk) disable iff (rst)
    all_ones_cond |=> stat[ST_ONES]); // R8
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    ($past(irq_mask) == '0) |-> irq_n); // R10
endmodule

bind ber_stat_core ber_stat_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .sync_live(sync_live), .lat_rise(lat_rise),
  .bit_cnt(bit_cnt), .err_cnt(err_cnt), .bit_hold(bit_hold), .stat(stat),
  .clr(clr), .bit_wrap(bit_wrap), .all_ones_cond(all_ones_cond),
  .irq_mask(irq_mask), .irq_n(irq_n)
);

// File: tb/ber_stat_core_tb_top.sv
`timescale 1ns/1ps
module ber_stat_core_tb_top;
  localparam int CW = 10;
  localparam logic [3:0] STA = 4'd8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_vld = 0, bit_err = 0, sync_live = 0;
  logic all_ones_cond = 0, all_zeros_cond = 0;
  logic latch_pin = 0, latch_ctl = 0, rd_stb = 0;
  logic [3:0] rd_addr = '0;
  logic [7:0] irq_mask = '0;
  logic [7:0] rd_data;
  logic irq_n;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ber_stat_core #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_err(bit_err),
    .sync_live(sync_live), .all_ones_cond(all_ones_cond),
    .all_zeros_cond(all_zeros_cond), .latch_pin(latch_pin),
    .latch_ctl(latch_ctl), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .irq_mask(irq_mask), .rd_data(rd_data), .irq_n(irq_n)
  );

  // {sync, bits, errors, expected bits, expected errors}
  localparam int VEC [6][5] = '{
    '{1,  20,   0,  20,   0},
    '{1,  37,   5,  37,   5},
    '{0,  15,   4,   0,   0},
    '{1, 300, 299, 300, 299},
    '{0,   8,   8,   0,   0},
    '{1,   1,   1,   1,   1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic run_bits(input int n, input int e);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_vld = 1'b1; bit_err = (i < e);
    end
    @(negedge clk); bit_vld = 1'b0; bit_err = 1'b0;
  endtask

  task automatic latch();
    @(negedge clk); latch_ctl = 1'b1;
    @(negedge clk); latch_ctl = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_stb = 1'b1; rd_addr = a;
    @(negedge clk); rd_stb = 1'b0; d = rd_data;
  endtask

  task automatic rd_cnt(input logic [3:0] base, output int v);
    logic [7:0] lo, hi;
    rd(base, lo);
    rd(base + 4'd1, hi);
    v = {hi, lo};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v;
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk("R11 rd_data after reset", rd_data, 0);
    chk("R11 irq_n after reset", irq_n, 1);
    rd_cnt(4'd0, v); chk("R11 held bit count", v, 0);
    rd_cnt(4'd4, v); chk("R11 held error count", v, 0);

    // table walk: R1 counting, R2 no counting without lock, R4 byte map
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); sync_live = VEC[k][0][0];
      latch();
      run_bits(VEC[k][1], VEC[k][2]);
      latch();
      rd_cnt(4'd0, v); chk(VEC[k][0] ? "R1 bit count" : "R2 bit count frozen", v, VEC[k][3]);
      rd_cnt(4'd4, v); chk(VEC[k][0] ? "R1 error count" : "R2 error count frozen", v, VEC[k][4]);
    end
    rd(4'd2, d); chk("R4 upper byte reads zero", d, 0);
    rd(4'd12, d); chk("R4 unmapped address", d, 0);

    // R3 latch in the same cycle as a counted bit
    @(negedge clk); sync_live = 1'b1;
    latch();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); bit_vld = 1'b1;
    end
    @(negedge clk); bit_vld = 1'b1; latch_ctl = 1'b1;
    @(negedge clk); bit_vld = 1'b0; latch_ctl = 1'b0;
    rd_cnt(4'd0, v); chk("R3 snapshot excludes concurrent bit", v, 5);
    latch();
    rd_cnt(4'd0, v); chk("R3 new interval starts at one", v, 1);
    // R3 pin path, level held high does not retrigger
    @(negedge clk); latch_pin = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); bit_vld = 1'b1;
    end
    @(negedge clk); bit_vld = 1'b0; latch_pin = 1'b0;
    latch();
    rd_cnt(4'd0, v); chk("R3 held level no retrigger", v, 3);

    // R5/R7 status rules
    rd(STA, d); rd(STA, d);
    chk("R5 clean status shows lock only", d, 8'h01);
    run_bits(3, 2);
    rd(STA, d); chk("R7 error seen set", d, 8'h09);
    rd(STA, d); chk("R7 error seen cleared by read", d, 8'h01);

    // R8 condition bits
    @(negedge clk); all_ones_cond = 1'b1;
    rd(STA, d); chk("R8 ones set", d, 8'h41);
    rd(STA, d); chk("R8 ones kept while condition holds", d, 8'h41);
    @(negedge clk); all_ones_cond = 1'b0;
    rd(STA, d); chk("R8 ones latched after condition ends", d, 8'h41);
    rd(STA, d); chk("R8 ones cleared", d, 8'h01);
    @(negedge clk); all_zeros_cond = 1'b1;
    rd(STA, d); chk("R8 zeros set", d, 8'h21);
    @(negedge clk); all_zeros_cond = 1'b0;
    rd(STA, d); chk("R8 zeros latched", d, 8'h21);
    rd(STA, d); chk("R8 zeros cleared", d, 8'h01);
    @(negedge clk); sync_live = 1'b0;
    rd(STA, d); chk("R5 loss of lock with live lock bit low", d, 8'h10);
    rd(STA, d); chk("R8 loss kept while unlocked", d, 8'h10);
    @(negedge clk); sync_live = 1'b1;
    rd(STA, d); chk("R8 loss latched after relock", d, 8'h11);
    rd(STA, d); chk("R8 loss cleared", d, 8'h01);

    // R9 event on the clearing edge
    @(negedge clk); rd_stb = 1'b1; rd_addr = STA; bit_vld = 1'b1; bit_err = 1'b1;
    @(negedge clk); rd_stb = 1'b0; bit_vld = 1'b0; bit_err = 1'b0; d = rd_data;
    chk("R9 read returns pre-event value", d, 8'h01);
    rd(STA, d); chk("R9 event wins over clear", d, 8'h09);
    rd(STA, d); chk("R9 cleared afterwards", d, 8'h01);

    // R6 wrap of both counters
    latch();
    run_bits(1024, 1024);
    run_bits(3, 1);
    latch();
    rd_cnt(4'd0, v); chk("R6 bit count wrapped and continued", v, 3);
    rd_cnt(4'd4, v); chk("R6 error count wrapped and continued", v, 1);
    rd(STA, d); chk("R6 overflow bits set", d, 8'h0F);
    rd(STA, d); chk("R7 overflow bits cleared", d, 8'h01);

    // R10 interrupt
    @(negedge clk); irq_mask = 8'h08;
    @(negedge clk); chk("R10 masked source idle", irq_n, 1);
    run_bits(1, 1);
    @(negedge clk); chk("R10 error seen raises interrupt", irq_n, 0);
    rd(STA, d);
    @(negedge clk); chk("R10 interrupt released after clear", irq_n, 1);
    irq_mask = 8'h10;
    @(negedge clk);
    @(negedge clk); chk("R10 unset source gives no interrupt", irq_n, 1);
    irq_mask = 8'h01;
    @(negedge clk);
    @(negedge clk); chk("R10 lock bit raises interrupt", irq_n, 0);
    irq_mask = 8'h00;
    @(negedge clk);
    @(negedge clk); chk("R10 mask cleared", irq_n, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule